// File: doc/BRIEF.md
# Serial Receive Path with Threshold-Interrupt FIFO

This block is the receive half of an asynchronous serial port. It watches a single serial input line and waits in idle for a high-to-low transition. It then confirms the start bit in the middle of its bit period and shifts in eight data bits, least significant first. A single stop bit follows. Every completed character is pushed into a 64-entry first-in first-out store. A processor-side read strobe drains that store.

A ready flag tells the processor that at least one character is waiting. An interrupt request rises when the fill count reaches a threshold chosen by a 2-bit select, provided receive interrupts are enabled. If a character completes while the store is already full, the character is discarded and a sticky overrun flag is raised. That flag stays set until the processor reads the line status. All bit timing is taken from a 16x oversampling enable pulse supplied from outside.

Top module: `uart_rx_fifo`

## Requirements
- R1: While idle, the receiver leaves idle only when a baud-enable sample shows the line low after the previous baud-enable sample showed it high. A line held high produces no character.
- R2: The start bit is rechecked on the 8th baud enable after the falling edge is detected. If the line is high at that point, the receiver returns to idle and stores nothing (false start).
- R3: Data bits are sampled 16 baud enables apart, least significant bit first, with the first sample 16 enables after the start check. One stop bit is sampled 16 enables after the last data bit, and the character is stored at that point whatever the stop level.
- R4: The store holds up to 64 characters in arrival order. A read strobe (rdEn high for one clock) while it is not empty removes the oldest character, which appears on rdData the clock after the strobe.
- R5: rxReady is high exactly when the store holds at least one character.
- R6: irq is high when rxIntEn is 1 and the fill count is at or above the threshold; trigSel 0, 1, 2 and 3 select 1, 16, 32 and 56 characters. irq falls as soon as the fill drops below the threshold or rxIntEn is 0.
- R7: A character that completes while the store holds 64 characters is discarded and sets overrun; the fill stays at 64.
- R8: overrun stays set until a clock with lsrRd high clears it. If a new overrun happens in the same clock, the flag stays set.
- R9: A read strobe while the store is empty leaves rdData and the fill count unchanged.
- R10: After reset the store is empty, rdData is 0, and rxReady, irq and overrun are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| baudTick | input | 1 | One-clock enable at 16 times the bit rate |
| rxIn | input | 1 | Serial input line, idle high |
| rdEn | input | 1 | Processor read strobe, pops one character |
| lsrRd | input | 1 | Processor line-status read, clears overrun |
| trigSel | input | 2 | Interrupt threshold select (1/16/32/56) |
| rxIntEn | input | 1 | Receive interrupt enable |
| rdData | output | 8 | Last character read from the store |
| rxReady | output | 1 | Store not empty |
| irq | output | 1 | Threshold interrupt request |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The assertions assume that baudTick is a one-clock pulse and that rxIn changes only between baud enables. They also assume rdEn and lsrRd are one-clock strobes driven well apart from the character push. The bench follows these assumptions. It produces a baud enable on every fourth clock and changes the line on falling clock edges, holding each bit for 64 clocks. It issues reads and status reads only after a frame has fully completed, so no push coincides with a pop during the checked scenarios.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rxState_t;

  typedef struct packed {
    logic shift;
    logic push;
  } rxStrobe_t;
endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      baudTick,
  input  logic      rxIn,
  output rxStrobe_t strb
);
  localparam int TCW  = $clog2(OVERSAMPLE);
  localparam int BCW  = $clog2(DATA_BITS);
  localparam int HALF = OVERSAMPLE / 2;

  rxState_t       state;
  logic [TCW-1:0] tickCnt;
  logic [BCW-1:0] bitIdx;
  logic           prevLine;
  logic           lastTick;

  assign lastTick = (tickCnt == TCW'(OVERSAMPLE - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tickCnt  <= '0;
      bitIdx   <= '0;
      prevLine <= 1'b1;
    end else if (baudTick) begin
      case (state)
        ST_IDLE: begin
          prevLine <= rxIn;
          if (prevLine && !rxIn) begin
            state   <= ST_START;
            tickCnt <= '0;
          end
        end
        ST_START: begin
          if (tickCnt == TCW'(HALF - 1)) begin
            tickCnt <= '0;
            bitIdx  <= '0;
            if (rxIn) begin
              state    <= ST_IDLE;
              prevLine <= 1'b1;
            end else begin
              state <= ST_DATA;
            end
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (lastTick) begin
            tickCnt <= '0;
            if (bitIdx == BCW'(DATA_BITS - 1)) state <= ST_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: begin
          if (lastTick) begin
            tickCnt  <= '0;
            state    <= ST_IDLE;
            prevLine <= rxIn;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    strb.shift = baudTick && (state == ST_DATA) && lastTick;
    strb.push  = baudTick && (state == ST_STOP) && lastTick;
  end

  // R2: a high line at the start check sends the receiver back to idle
  p_false_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && baudTick && tickCnt == TCW'(HALF - 1) && rxIn) |=> (state == ST_IDLE));

  // R1: idle is left only through a detected falling edge
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !(baudTick && prevLine && !rxIn)) |=> (state == ST_IDLE));

  // R3: shifting and storing never happen in the same clock
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.shift, strb.push}));
endmodule

// File: rtl/uart_rx_dpath.sv
module uart_rx_dpath
  import uart_rx_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxIn,
  input  rxStrobe_t            strb,
  input  logic                 rdEn,
  input  logic                 lsrRd,
  input  logic [1:0]           trigSel,
  input  logic                 rxIntEn,
  output logic [DATA_BITS-1:0] rdData,
  output logic                 rxReady,
  output logic                 irq,
  output logic                 overrun
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_BITS-1:0] shiftReg;
  logic [DATA_BITS-1:0] mem [DEPTH];
  logic [PTR_W-1:0]     wrPtr, rdPtr;
  logic [CNT_W-1:0]     fillCnt;
  logic [CNT_W-1:0]     trigLevel;
  logic                 isFull, isEmpty, doPush, doPop, dropByte;

  assign isFull   = (fillCnt == CNT_W'(DEPTH));
  assign isEmpty  = (fillCnt == '0);
  assign doPush   = strb.push && !isFull;
  assign dropByte = strb.push && isFull;
  assign doPop    = rdEn && !isEmpty;

  always_comb begin
    case (trigSel)
      2'd0:    trigLevel = CNT_W'(1);
      2'd1:    trigLevel = CNT_W'(DEPTH / 4);
      2'd2:    trigLevel = CNT_W'(DEPTH / 2);
      default: trigLevel = CNT_W'(DEPTH - DEPTH / 8);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strb.shift) shiftReg <= {rxIn, shiftReg[DATA_BITS-1:1]};
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= shiftReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fillCnt <= '0;
      rdData  <= '0;
      overrun <= 1'b0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop) begin
        rdPtr  <= rdPtr + 1'b1;
        rdData <= mem[rdPtr];
      end
      case ({doPush, doPop})
        2'b10:   fillCnt <= fillCnt + 1'b1;
        2'b01:   fillCnt <= fillCnt - 1'b1;
        default: fillCnt <= fillCnt;
      endcase
      if (dropByte) overrun <= 1'b1;
      else if (lsrRd) overrun <= 1'b0;
    end
  end

  assign rxReady = !isEmpty;
  assign irq     = rxIntEn && (fillCnt >= trigLevel);

  // R4: the fill count never passes the store depth
  p_fill_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= CNT_W'(DEPTH));

  // R7: a character arriving at a full store raises overrun
  p_overflow_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && isFull) |=> overrun);

  // R7: a full store does not grow
  p_no_grow_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    (isFull && !rdEn) |=> isFull);

  // R8: overrun holds until a status read
  p_ovr_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !lsrRd) |=> overrun);

  // R9: a read of an empty store changes nothing
  p_empty_rd_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && isEmpty && !strb.push) |=> ($stable(rdData) && isEmpty));
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 baudTick,
  input  logic                 rxIn,
  input  logic                 rdEn,
  input  logic                 lsrRd,
  input  logic [1:0]           trigSel,
  input  logic                 rxIntEn,
  output logic [DATA_BITS-1:0] rdData,
  output logic                 rxReady,
  output logic                 irq,
  output logic                 overrun
);
  rxStrobe_t strb;

  uart_rx_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxIn(rxIn), .strb(strb)
  );

  uart_rx_dpath #(.DEPTH(DEPTH), .DATA_BITS(DATA_BITS)) u_dpath (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .strb(strb), .rdEn(rdEn),
    .lsrRd(lsrRd), .trigSel(trigSel), .rxIntEn(rxIntEn), .rdData(rdData),
    .rxReady(rxReady), .irq(irq), .overrun(overrun)
  );
endmodule

// File: tb/uart_rx_fifo_tb.sv
module uart_rx_fifo_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       rxIn = 1'b1;
  logic       rdEn = 1'b0;
  logic       lsrRd = 1'b0;
  logic [1:0] trigSel = 2'd0;
  logic       rxIntEn = 1'b0;
  logic [7:0] rdData;
  logic       rxReady, irq, overrun;
  logic [1:0] divCnt = 2'd0;
  int         nChecks = 0;
  int         nFails = 0;

  uart_rx_fifo u_dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxIn(rxIn), .rdEn(rdEn),
    .lsrRd(lsrRd), .trigSel(trigSel), .rxIntEn(rxIntEn), .rdData(rdData),
    .rxReady(rxReady), .irq(irq), .overrun(overrun)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    divCnt   <= divCnt + 2'd1;
    baudTick <= (divCnt == 2'd3);
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk) rxIn = 1'b0;
    repeat (64) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxIn = b[i];
      repeat (64) @(negedge clk);
    end
    rxIn = 1'b1;
    repeat (96) @(negedge clk);
  endtask

  task automatic readByte();
    @(negedge clk) rdEn = 1'b1;
    @(negedge clk) rdEn = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 rxReady", rxReady, 0);
    check("R10 irq", irq, 0);
    check("R10 overrun", overrun, 0);
    check("R10 rdData", rdData, 0);
  endtask

  task automatic t_idle();
    repeat (800) @(negedge clk);
    check("R1 idle high line stores nothing", rxReady, 0);
  endtask

  task automatic t_single();
    trigSel = 2'd0;
    rxIntEn = 1'b1;
    sendByte(8'hA5);
    check("R5 ready after one byte", rxReady, 1);
    check("R6 irq at threshold 1", irq, 1);
    readByte();
    check("R3 byte value lsb first", rdData, 8'hA5);
    check("R5 ready after drain", rxReady, 0);
    check("R6 irq after drain", irq, 0);
  endtask

  task automatic t_false_start();
    @(negedge clk) rxIn = 1'b0;
    repeat (16) @(negedge clk);
    rxIn = 1'b1;
    repeat (800) @(negedge clk);
    check("R2 false start stores nothing", rxReady, 0);
  endtask

  task automatic t_empty_read();
    readByte();
    check("R9 rdData kept on empty read", rdData, 8'hA5);
    check("R9 still empty", rxReady, 0);
    sendByte(8'h3C);
    readByte();
    check("R9 fill unchanged by empty read", rdData, 8'h3C);
    check("R9 empty after one pop", rxReady, 0);
  endtask

  task automatic t_trigger16();
    trigSel = 2'd1;
    rxIntEn = 1'b1;
    for (int i = 0; i < 15; i++) sendByte(8'(i * 7 + 3));
    check("R6 no irq below 16", irq, 0);
    sendByte(8'(15 * 7 + 3));
    check("R6 irq at 16", irq, 1);
    rxIntEn = 1'b0;
    @(negedge clk);
    check("R6 irq masked when disabled", irq, 0);
    rxIntEn = 1'b1;
    readByte();
    check("R6 irq falls below threshold", irq, 0);
    check("R4 first byte out", rdData, 3);
    for (int i = 1; i < 16; i++) begin
      readByte();
      check("R4 arrival order", rdData, (i * 7 + 3) & 8'hFF);
    end
    check("R5 empty after trigger test", rxReady, 0);
  endtask

  task automatic t_overrun();
    trigSel = 2'd3;
    rxIntEn = 1'b1;
    for (int i = 0; i < 55; i++) sendByte(8'(i + 64));
    check("R6 no irq below 56", irq, 0);
    sendByte(8'(55 + 64));
    check("R6 irq at 56", irq, 1);
    for (int i = 56; i < 64; i++) sendByte(8'(i + 64));
    check("R7 no overrun when just full", overrun, 0);
    sendByte(8'hEE);
    check("R7 overrun on full", overrun, 1);
    for (int i = 0; i < 64; i++) begin
      readByte();
      check("R7 stored bytes intact", rdData, i + 64);
    end
    check("R7 dropped byte not stored", rxReady, 0);
    check("R8 overrun sticky after reads", overrun, 1);
    @(negedge clk) lsrRd = 1'b1;
    @(negedge clk) lsrRd = 1'b0;
    check("R8 overrun cleared by status read", overrun, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    t_idle();
    t_single();
    t_false_start();
    t_empty_read();
    t_trigger16();
    t_overrun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule